// File: doc/BRIEF.md
# Split-Address I2C Identification Reader

This block is an I2C master sequencer that fetches three identification bytes from a target device. The target has an unusual access model. It takes a register offset on one 7-bit address, and it returns the register contents on a second 7-bit address. For each register, the block writes a one-byte offset to the command address and closes that transfer with a STOP. It then opens a separate transfer and reads one byte from the data address. After all three bytes are in, it decodes the version byte into a revision number and an embedded flash size, and it raises flags for a bad ID or an undecodable version.

Software or a parent controller pulses `start_i` and watches `busy_o` and `done_o`. Bus timing is set by an external bit-rate enable `tick_i`. Every SCL period spans four ticks. The bus pins are open-drain: an `*_oe_o` output of 1 pulls the line low, and 0 releases it. No other master may use the bus, and the target may not stretch the clock.

Top module: `id_reader`

## Requirements
- R1: A `start_i` pulse while idle raises `busy_o` on the next cycle and clears all bytes, decoded fields and error flags on that same edge. A `start_i` pulse while busy has no effect: it causes no extra bus transfer, and the results of the run in progress do not change.
- R2: Offsets 0x00, 0x01 and 0x02 are read in that order. Each read writes address byte 0xB4 (address 0x5A, write) and then the offset byte, followed by address byte 0x6B (address 0x35, read) and one data byte. The bytes land in `id1_o`, `id2_o` and `ver_o`.
- R3: Every transfer opens with a START and closes with a STOP. A START never occurs inside a transfer, so the number of STARTs equals the number of STOPs.
- R4: The master leaves SDA released (NACK) on the ninth clock of each data-byte read, and a STOP follows.
- R5: If an address byte or the offset byte is not acknowledged, the block issues a STOP and ends the run with `err_xfer_o`=1. The other three error flags, `rev_o` and `flash_kb_o` are then 0. Bytes read before the failure are kept, and the rest read 0. No later register is accessed.
- R6: The open-drain enables change only in the cycle after a `tick_i` pulse. Both lines are released whenever `busy_o` is low.
- R7: After a run with no transfer error, `err_id_o` is 1 exactly when `id1_o` is not 0x83.
- R8: `rev_o` = `ver_o[2:0]`. For revisions 0 to 2, size code `ver_o[7:4]` values 0, 4 and 8 give `flash_kb_o` 128, 192 and 256. Any other code sets `err_size_o`.
- R9: For revision 3, size codes 0, 2, 4, 6 and 8 give 128, 192, 256, 384 and 512. Any other code sets `err_size_o`.
- R10: Revisions 4 to 7 set `err_rev_o` and leave `err_size_o` at 0. `flash_kb_o` is 0 whenever `err_size_o` or `err_rev_o` is set.
- R11: `done_o` is a single-cycle pulse in the first cycle in which `busy_o` is low after a run, on success and on failure alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an identification run |
| tick_i | input | 1 | Bus timing enable, four per SCL period |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| id1_o | output | 8 | Byte read from offset 0x00 |
| id2_o | output | 8 | Byte read from offset 0x01 |
| ver_o | output | 8 | Version byte from offset 0x02 |
| rev_o | output | 3 | Decoded revision |
| flash_kb_o | output | 10 | Decoded flash size in KB, 0 if unknown |
| err_xfer_o | output | 1 | A byte was not acknowledged |
| err_id_o | output | 1 | First ID byte is not 0x83 |
| err_size_o | output | 1 | Size code unknown for the revision |
| err_rev_o | output | 1 | Revision unknown |

## Verification
The assertions take the following for granted. `tick_i` is a plain single-cycle enable. `sda_i` reflects only this master and one well-behaved target. SCL is never held low by anyone else. `start_i` matters only while idle. The stimulus keeps to these limits. The bench has one behavioural target that changes SDA only while SCL is low, except at START and STOP. The bench makes the tick at a fixed rate, issues starts from the idle state, and adds only the deliberate extra start pulses in the middle of a run. Random version and ID bytes, and random NACK points, all stay inside that target model.

// File: rtl/idrd_pkg.sv
package idrd_pkg;
  typedef enum logic [1:0] {BC_START, BC_STOP, BC_WRITE, BC_READ} bus_cmd_e;
  localparam int unsigned NUM_REGS = 3;
  localparam int unsigned ID1_IDX  = 0;
  localparam int unsigned ID2_IDX  = 1;
  localparam int unsigned VER_IDX  = 2;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);
endpackage

// File: rtl/idrd_bit_engine.sv
module idrd_bit_engine
  import idrd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cmd_valid_i,
  input  bus_cmd_e   cmd_i,
  input  logic [7:0] wdata_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       done_o,
  output logic       ack_o,
  output logic [7:0] rdata_o
);
  localparam int unsigned LAST_BIT = 8;

  typedef enum logic [1:0] {E_IDLE, E_START, E_STOP, E_BITS} eng_st_e;
  eng_st_e    st_q;
  logic [1:0] q_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  logic       rd_q, ack_q, scl_q, sda_q, done_q;
  logic       ack_slot;

  assign ack_slot = (bit_q == 4'(LAST_BIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= E_IDLE;
      q_q    <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      ack_q  <= 1'b0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        E_IDLE: begin
          if (cmd_valid_i) begin
            q_q   <= '0;
            bit_q <= '0;
            sh_q  <= wdata_i;
            rd_q  <= (cmd_i == BC_READ);
            unique case (cmd_i)
              BC_START: st_q <= E_START;
              BC_STOP:  st_q <= E_STOP;
              default:  st_q <= E_BITS;
            endcase
          end
        end
        E_START: if (tick_i) begin
          q_q <= q_q + 2'd1;
          unique case (q_q)
            2'd0: begin sda_q <= 1'b0; scl_q <= 1'b0; end
            2'd1: sda_q <= 1'b1;
            2'd2: scl_q <= 1'b1;
            default: begin st_q <= E_IDLE; done_q <= 1'b1; end
          endcase
        end
        E_STOP: if (tick_i) begin
          q_q <= q_q + 2'd1;
          unique case (q_q)
            2'd0: sda_q <= 1'b1;
            2'd1: scl_q <= 1'b0;
            2'd2: sda_q <= 1'b0;
            default: begin st_q <= E_IDLE; done_q <= 1'b1; end
          endcase
        end
        default: if (tick_i) begin
          q_q <= q_q + 2'd1;
          unique case (q_q)
            // SCL is low here; write data bits pull SDA, ack slot and reads release
            2'd0: sda_q <= !ack_slot && !rd_q && !sh_q[7];
            2'd1: scl_q <= 1'b0;
            2'd2: begin
              if (ack_slot)  ack_q <= !sda_i;
              else if (rd_q) sh_q  <= {sh_q[6:0], sda_i};
              else           sh_q  <= {sh_q[6:0], 1'b0};
            end
            default: begin
              scl_q <= 1'b1;
              if (ack_slot) begin
                st_q   <= E_IDLE;
                done_q <= 1'b1;
              end else begin
                bit_q <= bit_q + 4'd1;
              end
            end
          endcase
        end
      endcase
    end
  end

  assign scl_oe_o = scl_q;
  assign sda_oe_o = sda_q;
  assign done_o   = done_q;
  assign ack_o    = ack_q;
  assign rdata_o  = sh_q;
endmodule

// File: rtl/idrd_sequencer.sv
module idrd_sequencer
  import idrd_pkg::*;
#(
  parameter logic [6:0] CMD_ADDR  = 7'h5A,
  parameter logic [6:0] DATA_ADDR = 7'h35
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             eng_done_i,
  input  logic             eng_ack_i,
  output logic             cmd_valid_o,
  output bus_cmd_e         cmd_o,
  output logic [7:0]       wdata_o,
  output logic             clr_o,
  output logic             cap_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             pass_o
);
  localparam logic [2:0] STEP_READ = 3'd6;
  localparam logic [2:0] STEP_LAST = 3'd7;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} seq_st_e;
  seq_st_e          st_q;
  logic [2:0]       step_q;
  logic [IDX_W-1:0] idx_q;
  logic             abort_q, busy_q, done_q, fail_q, pass_q, cap_q;
  logic             step_wr;

  // steps: START, cmd addr, offset, STOP, START, data addr, read, STOP
  always_comb begin
    cmd_o   = BC_START;
    wdata_o = '0;
    step_wr = 1'b0;
    unique case (step_q)
      3'd1: begin cmd_o = BC_WRITE; wdata_o = {CMD_ADDR, 1'b0};  step_wr = 1'b1; end
      3'd2: begin cmd_o = BC_WRITE; wdata_o = 8'(idx_q);         step_wr = 1'b1; end
      3'd5: begin cmd_o = BC_WRITE; wdata_o = {DATA_ADDR, 1'b1}; step_wr = 1'b1; end
      3'd6: cmd_o = BC_READ;
      3'd3, 3'd7: cmd_o = BC_STOP;
      default: cmd_o = BC_START;
    endcase
  end

  assign clr_o = (st_q == SQ_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      step_q  <= '0;
      idx_q   <= '0;
      abort_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      pass_q  <= 1'b0;
      cap_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      cap_q  <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          st_q    <= SQ_ISSUE;
          busy_q  <= 1'b1;
          step_q  <= '0;
          idx_q   <= '0;
          abort_q <= 1'b0;
          fail_q  <= 1'b0;
          pass_q  <= 1'b0;
        end
        SQ_ISSUE: st_q <= SQ_WAIT;
        default: if (eng_done_i) begin
          st_q <= SQ_ISSUE;
          if (step_wr && !eng_ack_i) begin
            abort_q <= 1'b1;
            step_q  <= STEP_LAST;
          end else if (step_q == STEP_LAST) begin
            if (abort_q || idx_q == IDX_W'(NUM_REGS - 1)) begin
              st_q   <= SQ_IDLE;
              busy_q <= 1'b0;
              done_q <= 1'b1;
              fail_q <= abort_q;
              pass_q <= !abort_q;
            end else begin
              idx_q  <= idx_q + 1'b1;
              step_q <= '0;
            end
          end else begin
            cap_q  <= (step_q == STEP_READ);
            step_q <= step_q + 3'd1;
          end
        end
      endcase
    end
  end

  assign cmd_valid_o = (st_q == SQ_ISSUE);
  assign cap_o       = cap_q;
  assign idx_o       = idx_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign pass_o      = pass_q;
endmodule

// File: rtl/idrd_decode.sv
module idrd_decode #(
  parameter int unsigned REV_W    = 3,
  parameter int unsigned KB_W     = 10,
  parameter int unsigned LATE_REV = 3
) (
  input  logic [7:0]       ver_i,
  output logic [REV_W-1:0] rev_o,
  output logic [KB_W-1:0]  kb_o,
  output logic             size_bad_o,
  output logic             rev_bad_o
);
  logic [3:0] code;
  assign code  = ver_i[7:4];
  assign rev_o = ver_i[REV_W-1:0];

  always_comb begin
    kb_o       = '0;
    size_bad_o = 1'b0;
    rev_bad_o  = 1'b0;
    if (rev_o < REV_W'(LATE_REV)) begin
      unique case (code)
        4'd0: kb_o = KB_W'(128);
        4'd4: kb_o = KB_W'(192);
        4'd8: kb_o = KB_W'(256);
        default: size_bad_o = 1'b1;
      endcase
    end else if (rev_o == REV_W'(LATE_REV)) begin
      unique case (code)
        4'd0: kb_o = KB_W'(128);
        4'd2: kb_o = KB_W'(192);
        4'd4: kb_o = KB_W'(256);
        4'd6: kb_o = KB_W'(384);
        4'd8: kb_o = KB_W'(512);
        default: size_bad_o = 1'b1;
      endcase
    end else begin
      rev_bad_o = 1'b1;
    end
  end
endmodule

// File: rtl/idrd_result.sv
module idrd_result
  import idrd_pkg::*;
#(
  parameter int unsigned REV_W     = 3,
  parameter int unsigned KB_W      = 10,
  parameter logic [7:0]  ID_EXPECT = 8'h83
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     cap_i,
  input  logic [IDX_W-1:0]         cap_idx_i,
  input  logic [7:0]               cap_data_i,
  input  logic                     pass_i,
  input  logic [REV_W-1:0]         rev_i,
  input  logic [KB_W-1:0]          kb_i,
  input  logic                     size_bad_i,
  input  logic                     rev_bad_i,
  output logic [NUM_REGS-1:0][7:0] bytes_o,
  output logic [REV_W-1:0]         rev_o,
  output logic [KB_W-1:0]          kb_o,
  output logic                     err_id_o,
  output logic                     err_size_o,
  output logic                     err_rev_o
);
  logic [NUM_REGS-1:0][7:0] bytes_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     bytes_q[g] <= '0;
      else if (clr_i)                                  bytes_q[g] <= '0;
      else if (cap_i && cap_idx_i == IDX_W'(g))        bytes_q[g] <= cap_data_i;
    end
  end

  assign bytes_o    = bytes_q;
  assign err_id_o   = pass_i && (bytes_q[ID1_IDX] != ID_EXPECT);
  assign err_size_o = pass_i && size_bad_i;
  assign err_rev_o  = pass_i && rev_bad_i;
  assign rev_o      = pass_i ? rev_i : '0;
  assign kb_o       = pass_i ? kb_i : '0;
endmodule

// File: rtl/id_reader.sv
module id_reader
  import idrd_pkg::*;
#(
  parameter logic [6:0]  CMD_ADDR  = 7'h5A,
  parameter logic [6:0]  DATA_ADDR = 7'h35,
  parameter logic [7:0]  ID_EXPECT = 8'h83,
  parameter int unsigned REV_W     = 3,
  parameter int unsigned KB_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       id1_o,
  output logic [7:0]       id2_o,
  output logic [7:0]       ver_o,
  output logic [REV_W-1:0] rev_o,
  output logic [KB_W-1:0]  flash_kb_o,
  output logic             err_xfer_o,
  output logic             err_id_o,
  output logic             err_size_o,
  output logic             err_rev_o
);
  logic                     cmd_valid, eng_done, eng_ack, clr, cap, pass;
  bus_cmd_e                 cmd;
  logic [7:0]               wdata, rdata;
  logic [IDX_W-1:0]         idx;
  logic [NUM_REGS-1:0][7:0] bytes;
  logic [REV_W-1:0]         dec_rev;
  logic [KB_W-1:0]          dec_kb;
  logic                     size_bad, rev_bad;

  idrd_bit_engine u_eng (
    .clk_i, .rst_ni, .tick_i,
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .wdata_i(wdata), .sda_i,
    .scl_oe_o, .sda_oe_o, .done_o(eng_done), .ack_o(eng_ack), .rdata_o(rdata)
  );

  idrd_sequencer #(.CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .eng_done_i(eng_done), .eng_ack_i(eng_ack),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .wdata_o(wdata),
    .clr_o(clr), .cap_o(cap), .idx_o(idx),
    .busy_o, .done_o, .fail_o(err_xfer_o), .pass_o(pass)
  );

  idrd_decode #(.REV_W(REV_W), .KB_W(KB_W)) u_dec (
    .ver_i(bytes[VER_IDX]), .rev_o(dec_rev), .kb_o(dec_kb),
    .size_bad_o(size_bad), .rev_bad_o(rev_bad)
  );

  idrd_result #(.REV_W(REV_W), .KB_W(KB_W), .ID_EXPECT(ID_EXPECT)) u_res (
    .clk_i, .rst_ni, .clr_i(clr), .cap_i(cap), .cap_idx_i(idx), .cap_data_i(rdata),
    .pass_i(pass), .rev_i(dec_rev), .kb_i(dec_kb),
    .size_bad_i(size_bad), .rev_bad_i(rev_bad),
    .bytes_o(bytes), .rev_o, .kb_o(flash_kb_o),
    .err_id_o, .err_size_o, .err_rev_o
  );

  assign id1_o = bytes[ID1_IDX];
  assign id2_o = bytes[ID2_IDX];
  assign ver_o = bytes[VER_IDX];
endmodule

module idrd_chk #(
  parameter int unsigned KB_W = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            tick_i,
  input logic            scl_oe_o,
  input logic            sda_oe_o,
  input logic            busy_o,
  input logic            done_o,
  input logic [KB_W-1:0] flash_kb_o,
  input logic            err_xfer_o,
  input logic            err_id_o,
  input logic            err_size_o,
  input logic            err_rev_o
);
  // R11
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  done_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R1
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R6
  scl_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(scl_oe_o));
  // R6
  sda_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sda_oe_o));
  // R6
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));
  // R5
  flags_quiet_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(err_xfer_o || err_id_o || err_size_o || err_rev_o));
  // R5
  xfer_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_xfer_o |-> !(err_id_o || err_size_o || err_rev_o) && flash_kb_o == '0);
  // R10
  rev_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_rev_o |-> !err_size_o && flash_kb_o == '0);
  // R10
  size_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_size_o |-> flash_kb_o == '0);
endmodule

bind id_reader idrd_chk #(.KB_W(KB_W)) u_chk (
  .clk_i, .rst_ni, .start_i, .tick_i, .scl_oe_o, .sda_oe_o, .busy_o, .done_o,
  .flash_kb_o, .err_xfer_o, .err_id_o, .err_size_o, .err_rev_o
);

// File: tb/id_reader_tb.sv
module id_reader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic tick = 1'b0;
  logic scl_oe, sda_oe, busy, done;
  logic [7:0] id1, id2, ver;
  logic [2:0] rev;
  logic [9:0] kb;
  logic e_x, e_id, e_sz, e_rv;
  logic scl_w, sda_w;
  logic slv_low = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tdiv = 0;

  // target model state
  logic [7:0] sl_regs [3];
  int   nack_kind = 0;
  int   nack_idx  = 0;
  int   start_cnt, stop_cnt, read_cnt, cmd_cnt, off_cnt;
  logic [7:0] off_log [8];
  bit   rep_start_bad, mack_bad;

  always #2 clk = ~clk;

  assign scl_w = !scl_oe;
  assign sda_w = !(sda_oe || slv_low);

  id_reader u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tick_i(tick), .sda_i(sda_w),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .done_o(done),
    .id1_o(id1), .id2_o(id2), .ver_o(ver), .rev_o(rev), .flash_kb_o(kb),
    .err_xfer_o(e_x), .err_id_o(e_id), .err_size_o(e_sz), .err_rev_o(e_rv)
  );

  always @(posedge clk) begin
    tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
    tick <= (tdiv == 2);
  end

  // behavioural target: offsets on 0x5A, data on 0x35
  bit p_scl = 1'b1, p_sda = 1'b1;
  bit active = 0, in_txn = 0, rdmode = 0, phase_data = 0, pend_rd = 0;
  int bitn = 0;
  logic [7:0] sh = '0, rdbyte = '0, last_off = '0;
  always @(scl_w or sda_w) begin
    if (scl_w && p_scl && p_sda && !sda_w) begin
      if (in_txn) rep_start_bad = 1;
      in_txn = 1; start_cnt++; active = 1; bitn = -1;
      rdmode = 0; phase_data = 0; pend_rd = 0; slv_low = 1'b0;
    end else if (scl_w && p_scl && !p_sda && sda_w) begin
      stop_cnt++; in_txn = 0; active = 0; rdmode = 0; slv_low = 1'b0;
    end else if (scl_w && !p_scl) begin
      if (active && !rdmode && bitn < 8) sh = {sh[6:0], sda_w};
      if (active && rdmode && bitn == 8 && !sda_w) mack_bad = 1;
    end else if (!scl_w && p_scl && active) begin
      bitn++;
      if (bitn == 8) begin
        if (rdmode) slv_low = 1'b0;
        else if (!phase_data) begin
          if (sh == 8'hB4) begin
            if (!(nack_kind == 1 && cmd_cnt == nack_idx)) slv_low = 1'b1;
            else active = 0;
            cmd_cnt++;
          end else if (sh == 8'h6B && !(nack_kind == 3 && last_off == 8'(nack_idx))) begin
            slv_low = 1'b1; pend_rd = 1; read_cnt++;
            rdbyte = (last_off < 3) ? sl_regs[last_off] : 8'hFF;
          end else active = 0;
        end else begin
          last_off = sh;
          if (off_cnt < 8) off_log[off_cnt] = sh;
          off_cnt++;
          if (!(nack_kind == 2 && sh == 8'(nack_idx))) slv_low = 1'b1;
          else active = 0;
        end
      end else if (bitn == 9) begin
        bitn = 0; slv_low = 1'b0;
        if (pend_rd) begin pend_rd = 0; rdmode = 1; slv_low = !rdbyte[7]; end
        else if (rdmode) active = 0;
        else phase_data = 1;
      end else if (rdmode) slv_low = !rdbyte[7-bitn];
    end
    p_scl = scl_w; p_sda = sda_w;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void ref_dec(input logic [7:0] v, output int kbv, output bit bs, output bit br);
    int r = int'(v[2:0]);
    int c = int'(v[7:4]);
    kbv = 0; bs = 0; br = 0;
    if (r < 3) begin
      case (c) 0: kbv = 128; 4: kbv = 192; 8: kbv = 256; default: bs = 1; endcase
    end else if (r == 3) begin
      case (c) 0: kbv = 128; 2: kbv = 192; 4: kbv = 256; 6: kbv = 384; 8: kbv = 512;
        default: bs = 1; endcase
    end else br = 1;
    if (bs || br) kbv = 0;
  endfunction

  task automatic run(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                     input int kind, input int nidx, input bit poke);
    bit pass = (kind == 0);
    int kbv, exp_txn, w;
    bit bs, br;
    logic [7:0] eb [3];
    sl_regs[0] = b0; sl_regs[1] = b1; sl_regs[2] = b2;
    nack_kind = kind; nack_idx = nidx;
    start_cnt = 0; stop_cnt = 0; read_cnt = 0; cmd_cnt = 0; off_cnt = 0;
    rep_start_bad = 0; mack_bad = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    // R1: busy and cleared results right after the accepting edge
    chk(busy == 1'b1, "R1", "busy after start", busy, 1);
    chk({id1, id2, ver, e_x, e_id, e_sz, e_rv} == '0, "R1", "cleared at start",
        int'({e_x, e_id, e_sz, e_rv}), 0);
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    chk(done == 1'b1, "R11", "done seen", done, 1);
    chk(busy == 1'b0, "R11", "busy low with done", busy, 0);
    for (int r = 0; r < 3; r++) eb[r] = (pass || r < nidx) ? sl_regs[r] : 8'h00;
    chk(id1 == eb[0] && id2 == eb[1] && ver == eb[2], "R2", "bytes",
        int'({id1, id2, ver}), int'({eb[0], eb[1], eb[2]}));
    chk(e_x == !pass, "R5", "err_xfer", e_x, !pass);
    ref_dec(b2, kbv, bs, br);
    if (pass) begin
      chk(e_id == (b0 != 8'h83), "R7", "err_id", e_id, b0 != 8'h83);
      chk(rev == b2[2:0], "R8", "rev", rev, b2[2:0]);
      chk(kb == 10'(kbv), (b2[2:0] == 3) ? "R9" : "R8", "flash_kb", kb, kbv);
      chk(e_sz == bs, (b2[2:0] == 3) ? "R9" : "R8", "err_size", e_sz, bs);
      chk(e_rv == br, "R10", "err_rev", e_rv, br);
      chk(off_cnt == 3 && off_log[0] == 0 && off_log[1] == 1 && off_log[2] == 2,
          "R2", "offset order", off_cnt, 3);
      chk(read_cnt == 3, "R2", "reads", read_cnt, 3);
      exp_txn = 6;
    end else begin
      chk({e_id, e_sz, e_rv, rev} == '0 && kb == '0, "R5", "flags on fail",
          int'({e_id, e_sz, e_rv}), 0);
      exp_txn = 2 * nidx + ((kind == 3) ? 2 : 1);
    end
    chk(start_cnt == exp_txn, poke ? "R1" : "R3", "start count", start_cnt, exp_txn);
    chk(stop_cnt == start_cnt && !rep_start_bad, "R3", "stop count", stop_cnt, start_cnt);
    chk(!mack_bad, "R4", "master nack on read", mack_bad, 0);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R6", "lines released", int'({scl_oe, sda_oe}), 0);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", done, 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, i1;
    int codes3 [5] = '{0, 2, 4, 6, 8};
    int codes0 [3] = '{0, 4, 8};
    void'($urandom(32'h1D5EED));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && scl_oe == 0 && sda_oe == 0, "R6", "reset lines", busy, 0);
    chk({id1, id2, ver, rev, kb, e_x, e_id, e_sz, e_rv} == '0, "R1", "reset outputs", id1, 0);
    // R8 early revisions with each code
    for (int r = 0; r < 3; r++) run(8'h83, 8'h20, {4'(codes0[r]), 1'b0, 3'(r)}, 0, 0, 0);
    // R9 revision 3, all codes
    for (int k = 0; k < 5; k++) run(8'h83, 8'h21, {4'(codes3[k]), 4'h3}, 0, 0, 0);
    run(8'h83, 8'h22, 8'h21, 0, 0, 0);   // R8 unknown code rev 1
    run(8'h83, 8'h22, 8'h53, 0, 0, 0);   // R9 unknown code rev 3
    run(8'h83, 8'h22, 8'h05, 0, 0, 0);   // R10 rev 5
    run(8'h83, 8'h22, 8'h8F, 0, 0, 0);   // R10 rev 7
    run(8'h84, 8'h22, 8'h40, 0, 0, 0);   // R7 bad id
    run(8'h83, 8'h22, 8'h43, 0, 0, 1);   // R1 start while busy
    for (int k = 1; k <= 3; k++)         // R5 each failure point
      for (int n = 0; n < 3; n++) run(8'h83, 8'h5C, 8'h02, k, n, 0);
    for (int t = 0; t < 14; t++) begin
      v  = 8'($urandom);
      if ($urandom % 2) v = {4'($urandom % 9), 4'($urandom % 4)};
      i1 = ($urandom % 4 == 0) ? 8'($urandom) : 8'h83;
      if ($urandom % 5 == 0) run(i1, 8'($urandom), v, 1 + int'($urandom % 3), int'($urandom % 3), 0);
      else run(i1, 8'($urandom), v, 0, 0, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule